// File: doc/BRIEF.md
# Branch Record Stack with Call-Stack Mode

This block keeps a short trace of taken control transfers. Each retired branch arrives with a type code, a privilege flag and its source and target addresses. A branch that survives the type and privilege filter becomes a record holding that from/to pair. Records sit in a circular array, and a top-of-stack index always points at the newest one. Software reads the records and the index through a small register port. Through the same port it sets a suppress-style select register and a control register.

A mode bit in the select register turns the array into a LIFO of the live call chain. Calls are pushed. A return removes the newest record, clears that slot and steps the index back, so records from leaf functions vanish. A performance-monitoring interrupt input can freeze all recording. Recording then stays frozen until software clears the frozen flag.

Top module: `brs_top`

## Requirements
- R1: After reset the select register, the control register and the top-of-stack index read 0, and every record reads from = 0 and to = 0.
- R2: In normal mode (select bit 9 = 0), a captured branch advances the index by one modulo DEPTH and stores its from/to pair in the slot the index then names. The index and the record are readable from the cycle after the branch is presented. Register map: 0 = select (bits 9:0), 1 = control (bits 2:0), 2 = index; record i has its source at 2·DEPTH + 2i and its target at 2·DEPTH + 2i + 1. Records and the index are read-only.
- R3: Type codes: 0 conditional, 1 near relative call, 2 near indirect call, 3 near return, 4 near indirect jump, 5 near relative jump, 6 far branch. Select bits 2 to 8, taken in that type order, each suppress one type when 1. Code 7 is never recorded.
- R4: Select bit 0 = 1 suppresses branches with the kernel flag set. Select bit 1 = 1 suppresses branches with the kernel flag clear.
- R5: With control bit 0 (enable) at 0, no branch changes the index or any record.
- R6: In call-stack mode (select bit 9 = 1), a captured return on a non-empty stack clears the newest record to zero and steps the index back by one modulo DEPTH. Any other captured branch is pushed as in R2.
- R7: A captured return in call-stack mode with zero live records leaves the index and all records unchanged.
- R8: The live-record count saturates at DEPTH. A push on a full stack overwrites the oldest slot, and afterwards only DEPTH returns pop before the stack is empty.
- R9: When control bit 1 (freeze on interrupt) is 1, an interrupt pulse sets control bit 2 (frozen). While bit 2 is 1 nothing is recorded, until software writes it back to 0. With bit 1 at 0 an interrupt pulse has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| br_valid | input | 1 | A taken branch retires this cycle |
| br_type | input | 3 | Branch type code |
| br_kern | input | 1 | Branch target is at kernel privilege |
| br_from | input | AW | Branch source address |
| br_to | input | AW | Branch target address |
| pmi | input | 1 | Performance-monitoring interrupt |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | IW+2 | Register address |
| reg_wdata | input | 10 | Register write data |
| reg_rdata | output | AW | Register read data (combinational) |

## Verification
The bench builds the block with DEPTH = 4 and AW = 16. The shallow stack makes the index wrap every few pushes and lets the stack fill and empty many times within a short run. A bench model built from the requirements predicts the index and every slot. The bench walks each single select bit against every type code and both privilege levels. On that small array it also reaches the empty-pop, full-push-overwrite and freeze corners in a few dozen cycles.

// File: rtl/brs_pkg.sv
package brs_pkg;

  typedef enum logic [2:0] {
    BT_COND     = 3'd0,
    BT_CALL_REL = 3'd1,
    BT_CALL_IND = 3'd2,
    BT_RET      = 3'd3,
    BT_JMP_IND  = 3'd4,
    BT_JMP_REL  = 3'd5,
    BT_FAR      = 3'd6
  } br_kind_e;

  localparam int SEL_W       = 10;
  localparam int SB_KERN     = 0;
  localparam int SB_USER     = 1;
  localparam int SB_COND     = 2;
  localparam int SB_CALL_REL = 3;
  localparam int SB_CALL_IND = 4;
  localparam int SB_RET      = 5;
  localparam int SB_JMP_IND  = 6;
  localparam int SB_JMP_REL  = 7;
  localparam int SB_FAR      = 8;
  localparam int SB_CSTACK   = 9;

  localparam int CTRL_W    = 3;
  localparam int CB_EN     = 0;
  localparam int CB_FRZ_EN = 1;
  localparam int CB_FROZEN = 2;

  localparam int RA_SEL  = 0;
  localparam int RA_CTRL = 1;
  localparam int RA_TOS  = 2;

endpackage

// File: rtl/brs_ctrl.sv
module brs_ctrl
  import brs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_sel,
  input  logic              wr_ctrl,
  input  logic [SEL_W-1:0]  wdata,
  input  logic              pmi,
  output logic [SEL_W-1:0]  sel_q,
  output logic [CTRL_W-1:0] ctrl_q
);

  logic [SEL_W-1:0]  sel_d;
  logic [CTRL_W-1:0] ctrl_d;
  logic              sel_ce, ctrl_ce, frz_set;

  assign frz_set = pmi & ctrl_q[CB_FRZ_EN];
  assign sel_ce  = wr_sel;
  assign ctrl_ce = wr_ctrl | frz_set;

  always_comb begin
    sel_d = wdata;
    ctrl_d = ctrl_q;
    if (wr_ctrl) ctrl_d = wdata[CTRL_W-1:0];
    if (frz_set) ctrl_d[CB_FROZEN] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      ctrl_q <= '0;
    end else begin
      if (sel_ce)  sel_q  <= sel_d;
      if (ctrl_ce) ctrl_q <= ctrl_d;
    end
  end

endmodule

// File: rtl/brs_filter.sv
module brs_filter
  import brs_pkg::*;
(
  input  logic              br_valid,
  input  logic [2:0]        br_type,
  input  logic              br_kern,
  input  logic              pmi,
  input  logic [SEL_W-1:0]  sel,
  input  logic [CTRL_W-1:0] ctrl,
  output logic              rec_push,
  output logic              rec_pop
);

  logic halt, type_sup, priv_sup, take;

  always_comb begin
    case (br_type)
      BT_COND:     type_sup = sel[SB_COND];
      BT_CALL_REL: type_sup = sel[SB_CALL_REL];
      BT_CALL_IND: type_sup = sel[SB_CALL_IND];
      BT_RET:      type_sup = sel[SB_RET];
      BT_JMP_IND:  type_sup = sel[SB_JMP_IND];
      BT_JMP_REL:  type_sup = sel[SB_JMP_REL];
      BT_FAR:      type_sup = sel[SB_FAR];
      default:     type_sup = 1'b1;
    endcase
  end

  assign halt     = ~ctrl[CB_EN] | ctrl[CB_FROZEN] | (pmi & ctrl[CB_FRZ_EN]);
  assign priv_sup = br_kern ? sel[SB_KERN] : sel[SB_USER];
  assign take     = br_valid & ~halt & ~type_sup & ~priv_sup;
  assign rec_pop  = take & sel[SB_CSTACK] & (br_type == BT_RET);
  assign rec_push = take & ~rec_pop;

endmodule

// File: rtl/brs_store.sv
module brs_store #(
  parameter int DEPTH = 16,
  parameter int AW    = 32,
  localparam int IW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [AW-1:0] br_from,
  input  logic [AW-1:0] br_to,
  input  logic [IW-1:0] rd_idx,
  output logic [IW-1:0] tos_q,
  output logic [CW-1:0] cnt_q,
  output logic [AW-1:0] rd_from,
  output logic [AW-1:0] rd_to
);

  localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);

  logic [DEPTH-1:0][AW-1:0] from_q, from_d, to_q, to_d;
  logic [IW-1:0] tos_d, tos_inc, tos_dec;
  logic [CW-1:0] cnt_d;
  logic          pop_ok, ce;

  assign pop_ok  = pop & (cnt_q != '0);
  assign ce      = push | pop_ok;
  assign tos_inc = tos_q + 1'b1;
  assign tos_dec = tos_q - 1'b1;

  always_comb begin
    from_d = from_q;
    to_d   = to_q;
    tos_d  = tos_q;
    cnt_d  = cnt_q;
    if (push) begin
      from_d[tos_inc] = br_from;
      to_d[tos_inc]   = br_to;
      tos_d           = tos_inc;
      if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
    end else if (pop_ok) begin
      from_d[tos_q] = '0;
      to_d[tos_q]   = '0;
      tos_d         = tos_dec;
      cnt_d         = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      from_q <= '0;
      to_q   <= '0;
      tos_q  <= '0;
      cnt_q  <= '0;
    end else if (ce) begin
      from_q <= from_d;
      to_q   <= to_d;
      tos_q  <= tos_d;
      cnt_q  <= cnt_d;
    end
  end

  assign rd_from = from_q[rd_idx];
  assign rd_to   = to_q[rd_idx];

endmodule

// File: rtl/brs_top.sv
module brs_top
  import brs_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = 32,
  localparam int IW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int RA_W = IW + 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            br_valid,
  input  logic [2:0]      br_type,
  input  logic            br_kern,
  input  logic [AW-1:0]   br_from,
  input  logic [AW-1:0]   br_to,
  input  logic            pmi,
  input  logic            reg_we,
  input  logic [RA_W-1:0] reg_addr,
  input  logic [SEL_W-1:0] reg_wdata,
  output logic [AW-1:0]   reg_rdata
);

  logic [1:0] rst_sync;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s_n = rst_sync[1];

  logic              is_entry, wr_sel, wr_ctrl, do_push, do_pop;
  logic [SEL_W-1:0]  sel_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic [IW-1:0]     tos_q;
  logic [CW-1:0]     cnt_q;
  logic [AW-1:0]     rd_from, rd_to;

  assign is_entry = reg_addr[RA_W-1];
  assign wr_sel   = reg_we & (reg_addr == RA_W'(RA_SEL));
  assign wr_ctrl  = reg_we & (reg_addr == RA_W'(RA_CTRL));

  brs_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .wr_sel (wr_sel),
    .wr_ctrl(wr_ctrl),
    .wdata  (reg_wdata),
    .pmi    (pmi),
    .sel_q  (sel_q),
    .ctrl_q (ctrl_q)
  );

  brs_filter u_filt (
    .br_valid(br_valid),
    .br_type (br_type),
    .br_kern (br_kern),
    .pmi     (pmi),
    .sel     (sel_q),
    .ctrl    (ctrl_q),
    .rec_push(do_push),
    .rec_pop (do_pop)
  );

  brs_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .push   (do_push),
    .pop    (do_pop),
    .br_from(br_from),
    .br_to  (br_to),
    .rd_idx (reg_addr[IW:1]),
    .tos_q  (tos_q),
    .cnt_q  (cnt_q),
    .rd_from(rd_from),
    .rd_to  (rd_to)
  );

  always_comb begin
    reg_rdata = '0;
    if (is_entry) begin
      reg_rdata = reg_addr[0] ? rd_to : rd_from;
    end else begin
      case (reg_addr)
        RA_W'(RA_SEL):  reg_rdata[SEL_W-1:0]  = sel_q;
        RA_W'(RA_CTRL): reg_rdata[CTRL_W-1:0] = ctrl_q;
        RA_W'(RA_TOS):  reg_rdata[IW-1:0]     = tos_q;
        default:        reg_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/brs_chk.sv
module brs_chk #(
  parameter int DEPTH = 16,
  localparam int IW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rec_push,
  input logic          rec_pop,
  input logic          enable,
  input logic          frozen,
  input logic [IW-1:0] tos_q,
  input logic [CW-1:0] cnt_q
);

  // R8
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  // R7
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_pop && cnt_q == '0) |=> ($stable(tos_q) && cnt_q == '0));

  // R2
  push_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_push |=> (tos_q == IW'($past(tos_q) + 1'b1)));

  // R6
  pop_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_pop && cnt_q != '0) |=> (tos_q == IW'($past(tos_q) - 1'b1)));

  // R9
  frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |=> $stable(tos_q));

  // R5
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> $stable(tos_q));

endmodule

bind brs_top brs_chk #(.DEPTH(DEPTH)) u_chk (
  .clk     (clk),
  .rst_n   (rst_s_n),
  .rec_push(do_push),
  .rec_pop (do_pop),
  .enable  (ctrl_q[0]),
  .frozen  (ctrl_q[2]),
  .tos_q   (tos_q),
  .cnt_q   (cnt_q)
);

// File: tb/sim_brs_top.sv
`timescale 1ns/1ps
module sim_brs_top;
  localparam int DEPTH = 4;
  localparam int AW    = 16;
  localparam int IW    = 2;
  localparam int RA_W  = IW + 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic            rst_n, br_valid, br_kern, pmi, reg_we;
  logic [2:0]      br_type;
  logic [AW-1:0]   br_from, br_to, reg_rdata;
  logic [RA_W-1:0] reg_addr;
  logic [9:0]      reg_wdata;

  brs_top #(.DEPTH(DEPTH), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_type(br_type),
    .br_kern(br_kern), .br_from(br_from), .br_to(br_to), .pmi(pmi),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );

  int n_chk = 0, n_bad = 0, seq = 0;
  bit done = 0;
  int m_tos = 0, m_cnt = 0;
  logic [AW-1:0] m_from [DEPTH];
  logic [AW-1:0] m_to   [DEPTH];
  logic [9:0] m_sel = '0;
  logic [2:0] m_ctrl = '0;

  task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input int a, output logic [AW-1:0] v);
    @(negedge clk);
    reg_addr = a[RA_W-1:0];
    #1 v = reg_rdata;
  endtask

  task automatic wr(input int a, input logic [9:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a[RA_W-1:0]; reg_wdata = d;
    @(posedge clk); #1 reg_we = 1'b0;
    if (a == 0) m_sel = d;
    if (a == 1) m_ctrl = d[2:0];
  endtask

  task automatic m_apply(input int t, input int k, input logic [AW-1:0] f, input logic [AW-1:0] d);
    bit sup;
    sup = (t == 7) ? 1'b1 : m_sel[t + 2];
    if (k != 0 ? m_sel[0] : m_sel[1]) sup = 1'b1;
    if (!m_ctrl[0] || m_ctrl[2]) sup = 1'b1;
    if (!sup) begin
      if (m_sel[9] && t == 3) begin
        if (m_cnt > 0) begin
          m_from[m_tos] = '0; m_to[m_tos] = '0;
          m_tos = (m_tos + DEPTH - 1) % DEPTH;
          m_cnt--;
        end
      end else begin
        m_tos = (m_tos + 1) % DEPTH;
        m_from[m_tos] = f; m_to[m_tos] = d;
        if (m_cnt < DEPTH) m_cnt++;
      end
    end
  endtask

  task automatic send(input int t, input int k);
    logic [AW-1:0] f, d;
    seq++;
    f = AW'(16'h1000 + seq); d = AW'(16'h8000 + seq);
    @(negedge clk);
    br_valid = 1'b1; br_type = t[2:0]; br_kern = k[0]; br_from = f; br_to = d;
    @(posedge clk); #1 br_valid = 1'b0;
    m_apply(t, k, f, d);
  endtask

  task automatic pmi_pulse();
    @(negedge clk); pmi = 1'b1;
    @(posedge clk); #1 pmi = 1'b0;
    if (m_ctrl[1]) m_ctrl[2] = 1'b1;
  endtask

  task automatic check_top(input string req);
    logic [AW-1:0] v;
    rd(2, v); check(req, v, AW'(m_tos));
    rd(2*DEPTH + 2*m_tos, v);     check(req, v, m_from[m_tos]);
    rd(2*DEPTH + 2*m_tos + 1, v); check(req, v, m_to[m_tos]);
  endtask

  task automatic check_all(input string req);
    logic [AW-1:0] v;
    rd(2, v); check(req, v, AW'(m_tos));
    for (int i = 0; i < DEPTH; i++) begin
      rd(2*DEPTH + 2*i, v);     check(req, v, m_from[i]);
      rd(2*DEPTH + 2*i + 1, v); check(req, v, m_to[i]);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [AW-1:0] v;
    string tag;
    for (int i = 0; i < DEPTH; i++) begin m_from[i] = '0; m_to[i] = '0; end
    rst_n = 1'b0; br_valid = 1'b0; br_type = '0; br_kern = 1'b0;
    br_from = '0; br_to = '0; pmi = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(0, v); check("R1", v, '0);
    rd(1, v); check("R1", v, '0);
    check_all("R1");

    // R5 disabled: nothing recorded
    send(1, 0);
    check_all("R5");

    // sweep: each single select bit against every type and privilege
    wr(1, 10'b001);
    for (int b = -1; b < 9; b++) begin
      wr(0, (b < 0) ? 10'd0 : 10'(1 << b));
      rd(0, v); check("R2", v, AW'(m_sel));
      for (int t = 0; t < 8; t++) begin
        for (int k = 0; k < 2; k++) begin
          send(t, k);
          tag = (b < 0) ? ((t == 7) ? "R3" : "R2") : ((b < 2) ? "R4" : "R3");
          check_top(tag);
        end
      end
    end

    // R5 enable off again after activity
    wr(1, 10'b000);
    send(0, 0);
    check_all("R5");
    wr(1, 10'b001);

    // R6/R7 call-stack mode: drain then pop on empty
    wr(0, 10'h3C4);
    for (int i = 0; i <= DEPTH; i++) begin
      send(3, 0);
      check_all((i == DEPTH) ? "R7" : "R6");
    end
    send(5, 0);
    check_all("R3");
    send(1, 0); check_all("R6");
    send(2, 1); check_all("R6");
    send(3, 0); check_all("R6");
    send(1, 1); check_all("R6");

    // R8 push past full, then pops stop after DEPTH
    while (m_cnt > 0) send(3, 0);
    for (int i = 0; i < DEPTH + 2; i++) send(1, 0);
    check_all("R8");
    for (int i = 0; i < DEPTH; i++) send(3, 0);
    check_all("R8");
    send(3, 0);
    check_all("R8");

    // R9 freeze on interrupt
    wr(0, 10'd0);
    wr(1, 10'b011);
    pmi_pulse();
    rd(1, v); check("R9", v, AW'(3'b111));
    send(1, 0);
    check_all("R9");
    wr(1, 10'b011);
    send(1, 0);
    check_all("R9");
    wr(1, 10'b001);
    pmi_pulse();
    rd(1, v); check("R9", v, AW'(3'b001));
    send(4, 1);
    check_all("R9");

    finish_run();
  end

endmodule